// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits between a serial bus engine and a non-volatile memory array. It gathers the data bytes of one write sequence into a 16-byte page buffer. When the bus engine reports the end of the sequence, the block programs the whole page in one timed program cycle. The bus engine opens a sequence by giving a page number and a starting byte offset. Each data byte then goes to the current offset, and the offset advances within the page. If more than 16 bytes arrive, the offset wraps around and later bytes replace earlier ones.

A per-position loaded mask records which buffer slots received data. Only those slots are enabled on the array write port, so bytes that were not sent keep their old contents in the array. The program cycle lasts a parameterised number of clocks. During that time the busy flag is high and every input from the bus engine is ignored. When the cycle ends, the block issues one wide write with byte enables and clears the buffer. An abort strobe throws the buffered bytes away without starting a cycle.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, `busy` and `arr_we` are low and no buffer position is loaded, so a commit straight after reset starts no program cycle.
- R2: While idle, `seq_start` loads `seq_page` and `seq_offset`. A `byte_stb` in the same cycle stores its byte at `seq_offset`.
- R3: Each accepted byte is stored at the current offset, and the offset then advances by one modulo 16. The page number never changes within a sequence.
- R4: After the offset passes position 15 it wraps to 0. A later byte at an already loaded position replaces the earlier value, and the array write carries the last value.
- R5: A `commit_stb` with at least one loaded position makes `busy` high from the next clock edge for exactly `PROG_CYCLES` clock cycles.
- R6: `arr_we` is high for exactly one cycle, the first cycle after `busy` falls, and never otherwise. In that cycle `arr_page` is the sequence page, and bit i of `arr_be` is set exactly for loaded position i. Position i's byte is in `arr_wdata[8*i+7:8*i]`.
- R7: A commit with no loaded position is ignored: `busy` stays low and no array write occurs.
- R8: `abort_stb` discards all loaded positions and starts no cycle. It takes precedence over `commit_stb` and `byte_stb` in the same cycle.
- R9: A `byte_stb` in the same cycle as `commit_stb` is included in the committed page.
- R10: While `busy` is high, `seq_start`, `byte_stb`, `commit_stb` and `abort_stb` have no effect. The pending write is unchanged and no second cycle follows.
- R11: After the array write the loaded mask is empty. A following sequence enables only its own positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_start | input | 1 | Opens a new write sequence |
| seq_page | input | PAGE_AW | Page number of the new sequence |
| seq_offset | input | 4 | Starting byte offset within the page |
| byte_stb | input | 1 | A data byte is valid this cycle |
| byte_data | input | 8 | Data byte |
| commit_stb | input | 1 | End of sequence, start programming |
| abort_stb | input | 1 | Discard the sequence |
| busy | output | 1 | Program cycle in progress |
| arr_we | output | 1 | One-cycle array write strobe |
| arr_page | output | PAGE_AW | Page being written |
| arr_be | output | 16 | Per-byte write enables |
| arr_wdata | output | 128 | Page data, byte i in bits 8i+7:8i |

## Verification
Two pairs of events can fall in the same cycle: a commit together with an abort, and a commit together with a final data byte. The bench drives each pair in a single cycle. For the abort pair, it judges success by `busy` staying low and by the absence of any array write. For the byte pair, it judges success by the enable and data of that byte in the later array write. Strobes driven during a program cycle are checked the same way: the count of busy cycles must still equal `PROG_CYCLES`, and the one write that follows must carry only the original bytes.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int PAGE_BYTES = 16;
    localparam int OFF_W      = $clog2(PAGE_BYTES);
    localparam int BYTE_W     = 8;
    localparam int PAGE_W     = PAGE_BYTES * BYTE_W;

    typedef logic [OFF_W-1:0]      off_t;
    typedef logic [BYTE_W-1:0]     byte_t;
    typedef logic [PAGE_BYTES-1:0] slot_mask_t;
    typedef logic [PAGE_W-1:0]     page_data_t;

    typedef struct packed {
        slot_mask_t be;
        page_data_t data;
    } page_img_t;

    typedef enum logic {TMR_IDLE, TMR_PROG} tmr_state_e;

    function automatic off_t next_off(off_t o);
        return o + off_t'(1);
    endfunction
endpackage

// File: rtl/pgw_pointer.sv
module pgw_pointer
    import pgw_pkg::*;
#(
    parameter int PAGE_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic               seq_start,
    input  logic [PAGE_AW-1:0] seq_page,
    input  off_t               seq_offset,
    input  logic               byte_stb,
    output logic [PAGE_AW-1:0] page_q,
    output off_t               slot_sel
);
    off_t off_q;

    always_comb slot_sel = seq_start ? seq_offset : off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            off_q  <= '0;
        end else if (accept) begin
            if (seq_start) page_q <= seq_page;
            if (seq_start || byte_stb)
                off_q <= byte_stb ? next_off(slot_sel) : slot_sel;
        end
    end

    // R3
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(accept && seq_start) |-> $stable(page_q));

    // R4
    off_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        $past(accept && byte_stb && !seq_start && off_q == off_t'(PAGE_BYTES-1))
        |-> off_q == '0);
endmodule

// File: rtl/pgw_slots.sv
module pgw_slots
    import pgw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       wr_en,
    input  off_t       wr_sel,
    input  byte_t      wr_data,
    output slot_mask_t mask,
    output page_data_t data
);
    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
        logic  m_q;
        byte_t d_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                m_q <= 1'b0;
                d_q <= '0;
            end else begin
                if (clr) m_q <= 1'b0;
                if (wr_en && wr_sel == off_t'(i)) begin
                    m_q <= 1'b1;
                    d_q <= wr_data;
                end
            end
        end
        assign mask[i]                 = m_q;
        assign data[i*BYTE_W +: BYTE_W] = d_q;
    end

    // R3
    slot_set_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) |-> mask[$past(wr_sel)]);
endmodule

// File: rtl/pgw_timer.sv
module pgw_timer
    import pgw_pkg::*;
#(
    parameter int PROG_CYCLES = 625000,
    parameter int CNT_W       = $clog2(PROG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy,
    output logic done
);
    tmr_state_e       state;
    logic [CNT_W-1:0] cnt;

    assign busy = (state == TMR_PROG);
    assign done = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TMR_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                TMR_IDLE: if (go) begin
                    state <= TMR_PROG;
                    cnt   <= CNT_W'(PROG_CYCLES - 1);
                end
                default: begin
                    if (cnt == '0) state <= TMR_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
            endcase
        end
    end

    logic [CNT_W-1:0] obs_len;
    always_ff @(posedge clk) begin
        if (rst)       obs_len <= '0;
        else if (busy) obs_len <= obs_len + 1'b1;
        else           obs_len <= '0;
    end

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> obs_len == CNT_W'(PROG_CYCLES));
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
    import pgw_pkg::*;
#(
    parameter int NUM_PAGES   = 64,
    parameter int PROG_CYCLES = 625000,
    localparam int PAGE_AW    = $clog2(NUM_PAGES),
    localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  seq_start,
    input  logic [PAGE_AW-1:0]    seq_page,
    input  logic [OFF_W-1:0]      seq_offset,
    input  logic                  byte_stb,
    input  logic [BYTE_W-1:0]     byte_data,
    input  logic                  commit_stb,
    input  logic                  abort_stb,
    output logic                  busy,
    output logic                  arr_we,
    output logic [PAGE_AW-1:0]    arr_page,
    output logic [PAGE_BYTES-1:0] arr_be,
    output logic [PAGE_W-1:0]     arr_wdata
);
    logic               accept, wr_en, clr, has_data, go, done;
    logic [PAGE_AW-1:0] page_q;
    off_t               slot_sel;
    slot_mask_t         mask;
    page_data_t         data;
    page_img_t          img_q;
    logic               we_q;
    logic [PAGE_AW-1:0] page_out_q;

    assign accept   = !busy;
    assign wr_en    = accept && byte_stb && !abort_stb;
    assign clr      = (accept && (abort_stb || seq_start)) || done;
    assign has_data = (seq_start ? 1'b0 : (|mask)) | wr_en;
    assign go       = accept && commit_stb && !abort_stb && has_data;

    pgw_pointer #(.PAGE_AW(PAGE_AW)) ptr_i (
        .clk(clk), .rst(rst), .accept(accept), .seq_start(seq_start),
        .seq_page(seq_page), .seq_offset(seq_offset), .byte_stb(byte_stb),
        .page_q(page_q), .slot_sel(slot_sel)
    );

    pgw_slots slots_i (
        .clk(clk), .rst(rst), .clr(clr), .wr_en(wr_en), .wr_sel(slot_sel),
        .wr_data(byte_data), .mask(mask), .data(data)
    );

    pgw_timer #(.PROG_CYCLES(PROG_CYCLES), .CNT_W(CNT_W)) tmr_i (
        .clk(clk), .rst(rst), .go(go), .busy(busy), .done(done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q       <= 1'b0;
            img_q      <= '0;
            page_out_q <= '0;
        end else begin
            we_q <= done;
            if (done) begin
                img_q.be   <= mask;
                img_q.data <= data;
                page_out_q <= page_q;
            end
        end
    end

    assign arr_we    = we_q;
    assign arr_page  = page_out_q;
    assign arr_be    = img_q.be;
    assign arr_wdata = img_q.data;

    // R6
    we_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> ($past(busy) && !busy));

    // R7
    nonempty_write_chk: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> arr_be != '0);

    // R11
    mask_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> mask == '0);

    // R10
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mask));

    // R8
    abort_discard_chk: assert property (@(posedge clk) disable iff (rst)
        $past(accept && abort_stb) |-> (mask == '0 && !busy));
endmodule

// File: tb/page_commit_ctrl_tb_top.sv
`timescale 1ns/1ps
module page_commit_ctrl_tb_top;
    localparam int NP  = 64;
    localparam int P   = 12;
    localparam int PAW = $clog2(NP);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             seq_start = 1'b0;
    logic [PAW-1:0]   seq_page = '0;
    logic [3:0]       seq_offset = '0;
    logic             byte_stb = 1'b0;
    logic [7:0]       byte_data = '0;
    logic             commit_stb = 1'b0;
    logic             abort_stb = 1'b0;
    logic             busy, arr_we;
    logic [PAW-1:0]   arr_page;
    logic [15:0]      arr_be;
    logic [127:0]     arr_wdata;

    always #4 clk = ~clk;

    page_commit_ctrl #(.NUM_PAGES(NP), .PROG_CYCLES(P)) dut_i (
        .clk(clk), .rst(rst), .seq_start(seq_start), .seq_page(seq_page),
        .seq_offset(seq_offset), .byte_stb(byte_stb), .byte_data(byte_data),
        .commit_stb(commit_stb), .abort_stb(abort_stb), .busy(busy),
        .arr_we(arr_we), .arr_page(arr_page), .arr_be(arr_be), .arr_wdata(arr_wdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        int          page;
        logic [15:0] be;
        logic [7:0]  bytes [16];
        string       tag;
    } exp_t;
    exp_t q[$];

    // bench-side model of the sequence in progress
    int          m_page = 0;
    int          m_off = 0;
    logic [15:0] m_mask = '0;
    logic [7:0]  m_buf [16];
    bit          m_busy = 0;

    task automatic cyc(input bit st, input int pg, input int off, input bit bs,
                       input logic [7:0] d, input bit cm, input bit ab, input string tag);
        exp_t it;
        seq_start = st; seq_page = PAW'(pg); seq_offset = 4'(off);
        byte_stb = bs; byte_data = d; commit_stb = cm; abort_stb = ab;
        if (!m_busy) begin
            if (st) begin m_page = pg; m_off = off; m_mask = '0; end
            if (ab) m_mask = '0;
            if (bs && !ab) begin
                m_buf[m_off] = d;
                m_mask[m_off] = 1'b1;
                m_off = (m_off + 1) % 16;
            end
            if (cm && !ab && m_mask != 0) begin
                it.page = m_page; it.be = m_mask; it.tag = tag;
                for (int i = 0; i < 16; i++) it.bytes[i] = m_buf[i];
                q.push_back(it);
                m_mask = '0;
                m_busy = 1;
            end
        end
        @(negedge clk);
        seq_start = 0; byte_stb = 0; commit_stb = 0; abort_stb = 0;
    endtask

    // counts busy samples from the current negedge; 'already' samples passed before
    task automatic wait_prog(input int already, input string tag);
        int n = already;
        while (busy === 1'b1 && n < P + 8) begin
            n++;
            @(negedge clk);
        end
        check(n == P, "R5", {tag, " busy length"}, n, P);
        check(arr_we === 1'b1, "R6", {tag, " write in first cycle after busy"}, arr_we, 1);
        m_busy = 0;
        @(negedge clk);
        check(arr_we === 1'b0, "R6", {tag, " write lasts one cycle"}, arr_we, 0);
    endtask

    task automatic expect_idle(input int cycles, input string req, input string tag);
        for (int i = 0; i < cycles; i++) begin
            check(busy === 1'b0, req, {tag, " busy stays low"}, busy, 0);
            @(negedge clk);
        end
    endtask

    // monitor: pops the scoreboard on every array write
    always @(negedge clk) begin
        if (!rst && arr_we === 1'b1) begin
            if (q.size() == 0) begin
                check(0, "R6", "array write with nothing expected", arr_be, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(arr_page == PAW'(e.page), "R3", {e.tag, " page"}, arr_page, e.page);
                check(arr_be == e.be, "R6", {e.tag, " byte enables"}, arr_be, e.be);
                for (int i = 0; i < 16; i++)
                    if (e.be[i])
                        check(arr_wdata[8*i +: 8] == e.bytes[i], "R4",
                              {e.tag, " byte value"}, arr_wdata[8*i +: 8], e.bytes[i]);
            end
        end
    end

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                if (!finished) begin
                    check(0, "R5", "watchdog expired", 0, 1);
                    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                    $finish;
                end
            end
        join_none

        repeat (4) @(negedge clk);
        rst = 0;

        // R1: reset state, commit on empty buffer
        check(busy === 1'b0, "R1", "busy after reset", busy, 0);
        check(arr_we === 1'b0, "R1", "arr_we after reset", arr_we, 0);
        cyc(0, 0, 0, 0, 8'h00, 1, 0, "R1");
        expect_idle(3, "R1", "commit after reset");

        // R2 / R5 / R6: one byte at page 3 offset 5
        cyc(1, 3, 5, 0, 8'h00, 0, 0, "R2");
        cyc(0, 0, 0, 1, 8'hA5, 0, 0, "R2");
        cyc(0, 0, 0, 0, 8'h00, 1, 0, "R2 single byte");
        wait_prog(0, "R2 single byte");

        // R3: full page from offset 0
        cyc(1, 10, 0, 0, 8'h00, 0, 0, "R3");
        for (int i = 0; i < 16; i++) cyc(0, 0, 0, 1, 8'(8'h10 + i), 0, 0, "R3");
        cyc(0, 0, 0, 0, 8'h00, 1, 0, "R3 full page");
        wait_prog(0, "R3 full page");

        // R4: 18 bytes from offset 14, wrap overwrites 14 and 15
        cyc(1, 20, 14, 0, 8'h00, 0, 0, "R4");
        for (int i = 0; i < 18; i++) cyc(0, 0, 0, 1, 8'(8'h40 + i), 0, 0, "R4");
        cyc(0, 0, 0, 0, 8'h00, 1, 0, "R4 wrap");
        wait_prog(0, "R4 wrap");

        // R2 start with byte in same cycle, R9 byte with commit
        cyc(1, 7, 2, 1, 8'h77, 0, 0, "R2");
        cyc(0, 0, 0, 1, 8'h78, 0, 0, "R2");
        cyc(0, 0, 0, 1, 8'h79, 1, 0, "R9 byte with commit");
        wait_prog(0, "R9 byte with commit");

        // R7: address only, then commit
        cyc(1, 9, 4, 0, 8'h00, 0, 0, "R7");
        cyc(0, 0, 0, 0, 8'h00, 1, 0, "R7");
        expect_idle(3, "R7", "empty commit");

        // R8: abort discards, commit afterwards is empty
        cyc(1, 5, 0, 0, 8'h00, 0, 0, "R8");
        cyc(0, 0, 0, 1, 8'h51, 0, 0, "R8");
        cyc(0, 0, 0, 1, 8'h52, 0, 0, "R8");
        cyc(0, 0, 0, 0, 8'h00, 0, 1, "R8");
        cyc(0, 0, 0, 0, 8'h00, 1, 0, "R8");
        expect_idle(3, "R8", "commit after abort");

        // R11: new sequence enables only its own byte
        cyc(1, 5, 9, 1, 8'h99, 0, 0, "R11");
        cyc(0, 0, 0, 0, 8'h00, 1, 0, "R11 own bytes only");
        wait_prog(0, "R11 own bytes only");

        // R8: abort and commit in the same cycle
        cyc(1, 12, 3, 1, 8'hC3, 0, 0, "R8");
        cyc(0, 0, 0, 1, 8'hC4, 1, 1, "R8");
        expect_idle(3, "R8", "abort with commit");

        // R10: strobes during busy are ignored
        cyc(1, 30, 6, 1, 8'hE6, 0, 0, "R10");
        cyc(0, 0, 0, 1, 8'hE7, 1, 0, "R10 busy ignore");
        cyc(1, 31, 0, 1, 8'h11, 0, 0, "R10");
        cyc(0, 0, 0, 1, 8'h22, 1, 0, "R10");
        cyc(0, 0, 0, 1, 8'h33, 0, 1, "R10");
        wait_prog(3, "R10 busy ignore");
        expect_idle(3, "R10", "no second cycle");

        check(q.size() == 0, "R6", "all expected writes seen", q.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule